// File: doc/BRIEF.md
# Dword Mailbox Window

This block is a one-way message channel between a producing processor and a consuming engine. The two sides share a circular store of 32-bit slots. The producer pushes one dword per write strobe through a single write-window port. The consumer pops one dword per read strobe through a single read-window port. The producer sends each message as a header dword followed by its payload dwords.

A packed status word lets software on either side find the occupancy without a dedicated counter. It carries the fixed slot count and two free-running 8-bit pointers. The filled count is the write pointer minus the read pointer, taken modulo 256. The empty count is the slot count minus the filled count.

Each side also has a notify strobe. When a side has written or consumed a message, it raises its strobe. This produces a single-cycle doorbell pulse toward the other side.

Top module: `mbx_dword_window`

## Requirements
- R1: While `rst` is sampled high, and after it, both pointers read zero, the overflow flag is clear and both doorbells are low.
- R2: `status_word` packs the slot count in bits 31:24, the write pointer in bits 23:16, the read pointer in bits 15:8 and the sticky overflow flag in bit 0. Bits 7:1 read zero.
- R3: A write strobe on a buffer that is not full stores `prod_wr_data` and advances the write pointer by one, modulo 256, after that clock edge.
- R4: A read strobe on a buffer that is not empty advances the read pointer by one. In the next cycle, `cons_rd_data` presents the oldest stored dword, so data leaves in the order it was written.
- R5: The filled count, (write pointer − read pointer) mod 256, never exceeds the slot count. Both pointers wrap from 255 to 0 without disturbing the count.
- R6: A write strobe on a full buffer is dropped. The write pointer and the stored data are unchanged, and the overflow flag is set and stays set until reset.
- R7: A read strobe on an empty buffer leaves the read pointer unchanged, and `cons_rd_data` is zero in the next cycle.
- R8: When both strobes arrive in one cycle, full and empty are judged on the state before that edge. On a full buffer the read proceeds and the write is dropped. On an empty buffer the write proceeds and the read returns zero.
- R9: A rising edge on `prod_ring` gives exactly one one-cycle pulse on `doorbell_to_cons` after the next clock edge, however long the strobe is held. `cons_ring` drives `doorbell_to_prod` in the same way.
- R10: The slot-count field equals the `DEPTH` parameter at all times and never changes at run time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_wr_en | input | 1 | Write-window strobe, one dword per cycle |
| prod_wr_data | input | 32 | Dword to store |
| prod_ring | input | 1 | Producer notify strobe |
| cons_rd_en | input | 1 | Read-window strobe, one dword per cycle |
| cons_rd_data | output | 32 | Dword popped by the previous read strobe, or zero if that read found the buffer empty |
| cons_ring | input | 1 | Consumer notify strobe |
| status_word | output | 32 | Packed slot count, pointers and overflow flag |
| overflow | output | 1 | Sticky flag for a dropped write |
| doorbell_to_cons | output | 1 | One-cycle pulse toward the consumer |
| doorbell_to_prod | output | 1 | One-cycle pulse toward the producer |

## Verification
The bench pushes the buffer to exactly full and then writes once more. A design that still accepts that write would corrupt the oldest slot and push the filled count past the slot count. The bench also issues read and write together on a full buffer and on an empty one. A design that judged fullness after the read would accept the extra write, and one that forwarded the write would return data instead of zero. Long random traffic runs both pointers past 255 several times. This exposes index logic that wraps at 256 rather than at the slot count. Holding a notify strobe for several cycles exposes a doorbell that is level-driven rather than edge-driven.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic [7:0] slots;
    logic [7:0] wptr;
    logic [7:0] rptr;
    logic [6:0] zero;
    logic       ovf;
  } mbx_status_t;

  function automatic logic [7:0] mbx_fill(input logic [7:0] w, input logic [7:0] r);
    return w - r;
  endfunction
endpackage

// File: rtl/mbx_ptr_ctrl.sv
module mbx_ptr_ctrl #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic             wr_go,
  output logic             rd_go,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       wptr,
  output logic [7:0]       rptr,
  output logic             ovf
);
  localparam logic [7:0]       DEPTH_B = 8'(DEPTH);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(DEPTH - 1);

  logic [7:0] fill;
  logic       full;
  logic       empty;

  assign fill  = mbx_pkg::mbx_fill(wptr, rptr);
  assign full  = (fill == DEPTH_B);
  assign empty = (fill == 8'd0);
  assign wr_go = wr_req & ~full;
  assign rd_go = rd_req & ~empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      wr_idx <= '0;
      rd_idx <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_go) begin
        wptr   <= wptr + 8'd1;
        wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
      end
      if (rd_go) begin
        rptr   <= rptr + 8'd1;
        rd_idx <= (rd_idx == LAST) ? '0 : rd_idx + 1'b1;
      end
      if (wr_req && full) ovf <= 1'b1;
    end
  end

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (rst)
    fill <= DEPTH_B);
  assert_wr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !full) |=> (wptr == $past(wptr) + 8'd1));
  assert_drop_full_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full) |=> ($stable(wptr) && ovf));
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  assert_empty_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty) |=> $stable(rptr));
endmodule

// File: rtl/mbx_slot_ram.sv
module mbx_slot_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell (
  input  logic clk,
  input  logic rst,
  input  logic ring,
  output logic pulse
);
  logic ring_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      ring_q <= ring;
      pulse  <= ring & ~ring_q;
    end
  end

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/mbx_dword_window.sv
module mbx_dword_window #(
  parameter int DEPTH = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prod_wr_en,
  input  logic [DW-1:0] prod_wr_data,
  input  logic          prod_ring,
  input  logic          cons_rd_en,
  output logic [DW-1:0] cons_rd_data,
  input  logic          cons_ring,
  output logic [31:0]   status_word,
  output logic          overflow,
  output logic          doorbell_to_cons,
  output logic          doorbell_to_prod
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NBELL = 2;

  logic             wr_go, rd_go;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wptr, rptr;
  logic [DW-1:0]    ram_q;
  logic             hit_q;
  logic [NBELL-1:0] rings, bells;
  mbx_pkg::mbx_status_t st;

  mbx_ptr_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst(rst), .wr_req(prod_wr_en), .rd_req(cons_rd_en),
    .wr_go(wr_go), .rd_go(rd_go), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .wptr(wptr), .rptr(rptr), .ovf(overflow)
  );

  mbx_slot_ram #(.DEPTH(DEPTH), .DW(DW), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .we(wr_go), .waddr(wr_idx), .wdata(prod_wr_data),
    .re(rd_go), .raddr(rd_idx), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else if (cons_rd_en) hit_q <= rd_go;
  end

  assign cons_rd_data = hit_q ? ram_q : '0;

  assign rings = {cons_ring, prod_ring};
  for (genvar g = 0; g < NBELL; g++) begin : g_bell
    mbx_doorbell u_bell (.clk(clk), .rst(rst), .ring(rings[g]), .pulse(bells[g]));
  end
  assign doorbell_to_cons = bells[0];
  assign doorbell_to_prod = bells[1];

  always_comb begin
    st.slots = 8'(DEPTH);
    st.wptr  = wptr;
    st.rptr  = rptr;
    st.zero  = '0;
    st.ovf   = overflow;
  end
  assign status_word = st;
endmodule

// File: tb/mbx_dword_window_test.sv
module mbx_dword_window_test;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, pr = 1'b0, cr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, status;
  logic        ovf, db_c, db_p;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] q[$];
  logic [7:0]  mw, mr;
  bit          movf, pr_prev, cr_prev;

  always #2 clk = ~clk;

  mbx_dword_window #(.DEPTH(D)) uut (
    .clk(clk), .rst(rst), .prod_wr_en(wr_en), .prod_wr_data(wr_data),
    .prod_ring(pr), .cons_rd_en(rd_en), .cons_rd_data(rd_data),
    .cons_ring(cr), .status_word(status), .overflow(ovf),
    .doorbell_to_cons(db_c), .doorbell_to_prod(db_p)
  );

  function automatic logic [31:0] exp_status();
    return {8'(D), mw, mr, 7'b0, movf};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 0; rd_en = 0; pr = 0; cr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status in reset", status, {8'(D), 24'h0});
    chk("R1 doorbells in reset", {30'h0, db_c, db_p}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    q.delete(); mw = 0; mr = 0; movf = 0; pr_prev = 0; cr_prev = 0;
  endtask

  task automatic step(input bit w, input logic [31:0] d, input bit r,
                      input bit p, input bit c);
    bit full, empty, edc, edp;
    logic [31:0] erd;
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; pr = p; cr = c;
    full  = (q.size() == D);
    empty = (q.size() == 0);
    erd   = empty ? 32'h0 : q[0];
    if (r && !empty) begin void'(q.pop_front()); mr++; end
    if (w && !full) begin q.push_back(d); mw++; end
    else if (w) movf = 1;
    edc = p & ~pr_prev; pr_prev = p;
    edp = c & ~cr_prev; cr_prev = c;
    @(posedge clk);
    #1;
    if (r) chk((w ? "R8 read data" : (empty ? "R7 empty read" : "R4 read data")), rd_data, erd);
    chk("R3 write pointer", {24'h0, status[23:16]}, {24'h0, mw});
    chk("R4 read pointer", {24'h0, status[15:8]}, {24'h0, mr});
    chk("R6 overflow flag", {31'h0, ovf}, {31'h0, movf});
    chk("R2 low byte", {24'h0, status[7:0]}, {24'h0, 7'b0, movf});
    chk("R10 depth field", {24'h0, status[31:24]}, 32'(D));
    chk("R5 fill count", 32'(8'(status[23:16] - status[15:8])), 32'(q.size()));
    chk("R9 doorbell to consumer", {31'h0, db_c}, {31'h0, edc});
    chk("R9 doorbell to producer", {31'h0, db_p}, {31'h0, edp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pw, prd;
    void'($urandom(32'd1234));
    do_reset();
    // R7: read on empty after reset
    step(0, 0, 1, 0, 0);
    // fill to exactly full, then R6 extra write
    for (int i = 0; i < D; i++) step(1, 32'hA000_0000 + i, 0, 0, 0);
    step(1, 32'hDEAD_BEEF, 0, 0, 0);
    // R8 on full: read proceeds, write dropped
    step(1, 32'h1111_1111, 1, 0, 0);
    for (int i = 0; i < D; i++) step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    // R8 on empty: write proceeds, read returns zero
    step(1, 32'h2222_2222, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    // R9 held strobes give single pulses
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    // R1 again and random phases with pointer wrap (R5)
    do_reset();
    for (int ph = 0; ph < 12; ph++) begin
      pw  = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 30 : 55;
      prd = (ph % 3 == 0) ? 30 : (ph % 3 == 1) ? 80 : 55;
      for (int k = 0; k < 200; k++)
        step(($urandom % 100) < pw, $urandom, ($urandom % 100) < prd,
             ($urandom % 8) == 0, ($urandom % 8) == 0);
    end
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule